// File: doc/BRIEF.md
# Shared-Period Dual PWM Timer Group

This block is a group of three 16-bit down counters. Channel 0 sets the period. Channels 1 and 2 each produce one PWM output, and both outputs share channel 0's period. Channel 0 runs freely. Each time it reaches zero it raises a one-cycle period event and reloads itself from its data register. Each of the other two channels is a one-shot counter. The period event re-arms it and loads its own data register, and that value sets the duty of its output.

Software writes a data register for each channel and fires start and stop trigger pulses for each channel. It can read every counter at any time and sees a running flag per channel. A stop freezes the counters and leaves the outputs where they are. A per-output enable hands the pin over to a software level bit. All counting is paced by a single-cycle count enable taken from the system clock.

Top module: `pwm_trio_timer`

## Requirements
- R1: After reset, every counter reads 0, every running flag is 0, the period event is low, and each internal PWM level is low, so an enabled output pin reads 0.
- R2: A pulse on bit 0 of `start_i` sets running flag 0 at the next clock edge and loads data register 0 into counter 0. A pulse on bit k (k = 1, 2) sets running flag k, and channel k then waits for a period event.
- R3: While channel 0 is running, each count enable decrements counter 0. When counter 0 is 0 and a count enable arrives, `tick_o` is high in that cycle and counter 0 reloads data register 0, so the period is data + 1 enables.
- R4: On a period event, a running PWM channel loads its data register into its counter at the next edge. It then decrements on each count enable until it reaches 0.
- R5: A PWM channel's output goes high at the first count enable after the period event that re-armed it.
- R6: A count enable that finds an armed PWM counter at 0 drives that output low. The counter then stays at 0 until the next period event. A data value of 0 gives no high pulse. A value at or above the period keeps the output high.
- R7: A pulse on bit k of `stop_i` clears running flag k. The counter freezes at its value, the period event is suppressed, and the PWM level is held.
- R8: With `oe_i[k-1]` = 1, pin `pwm_o[k-1]` shows channel k's PWM level. With it at 0, the pin shows `lvl_i[k-1]`.
- R9: A data register written while running does not disturb the current count. The new value is used only at that channel's next reload (start or period event).
- R10: `cnt_o[16k+15:16k]` always shows counter k, whether the channel is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Single-cycle count enable |
| start_i | input | 3 | Start trigger pulses, bit k for channel k |
| stop_i | input | 3 | Stop trigger pulses, bit k for channel k |
| wr_en | input | 3 | Data register write strobes, bit k for channel k |
| wr_data | input | 16 | Data to write |
| oe_i | input | 2 | PWM pin enable, bit k-1 for channel k |
| lvl_i | input | 2 | Software pin level used when the pin is disabled |
| cnt_o | output | 48 | Counter readback, channel k at bits 16k+15:16k |
| run_o | output | 3 | Running flags |
| tick_o | output | 1 | Period event pulse |
| pwm_o | output | 2 | PWM pins |

## Verification
The period event and the pin mux are combinational, so they are due in the same cycle as the inputs that cause them. Counters, running flags and PWM levels change at the first clock edge after a trigger or count enable. A PWM rise appears one enable after the event. The bench drives inputs on the falling edge and compares everything 1 ns later, before the next rising edge. It steps its reference model once per cycle, after the comparison, so each expected value lines up with the edge that produces it. Reset release passes through a two-flop synchronizer, so the bench idles for several cycles before the first start.

// File: rtl/pwm_trio_pkg.sv
package pwm_trio_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned N_PWM_DEF = 2;
endpackage

// File: rtl/pwm_period_ch.sv
module pwm_period_ch #(
  parameter int unsigned CW = pwm_trio_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          start,
  input  logic          stop,
  input  logic          wr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          tick
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] data_q, data_d, cnt_q, cnt_d;
  logic          run_q, run_d, tick_c;

  always_comb begin
    data_d = wr ? wr_data : data_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    tick_c = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = data_q;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && cnt_en) begin
      if (cnt_q == '0) begin
        tick_c = 1'b1;
        cnt_d  = data_q;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
    end
  end

  assign cnt  = cnt_q;
  assign run  = run_q;
  assign tick = tick_c;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == $past(data_q)));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(data_q)));
  assert_decr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_en && !start && !stop && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> ($stable(cnt_q) && !run_q));
endmodule

// File: rtl/pwm_duty_ch.sv
module pwm_duty_ch #(
  parameter int unsigned CW = pwm_trio_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          trig,
  input  logic          start,
  input  logic          stop,
  input  logic          wr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          level
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] data_q, data_d, cnt_q, cnt_d;
  logic          run_q, run_d, act_q, act_d, pend_q, pend_d, out_q, out_d;

  always_comb begin
    data_d = wr ? wr_data : data_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    act_d  = act_q;
    pend_d = pend_q;
    out_d  = out_q;
    if (start) begin
      run_d  = 1'b1;
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (stop) begin
      run_d  = 1'b0;
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (run_q) begin
      if (trig) begin
        cnt_d  = data_q;
        act_d  = 1'b1;
        pend_d = 1'b1;
      end else if (cnt_en && act_q) begin
        pend_d = 1'b0;
        if (cnt_q == '0) begin
          out_d = 1'b0;
          act_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
          if (pend_q) out_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      out_q  <= out_d;
    end
  end

  assign cnt   = cnt_q;
  assign run   = run_q;
  assign level = out_q;

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && run_q && !start && !stop) |=> (cnt_q == $past(data_q)));
  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && run_q && cnt_en && !trig && !start && !stop && cnt_q != '0) |=> out_q);
  assert_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && run_q && cnt_en && !trig && !start && !stop && cnt_q == '0) |=> (!out_q && cnt_q == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!run_q && $stable(out_q) && $stable(cnt_q)));
endmodule

// File: rtl/pwm_trio_timer.sv
module pwm_trio_timer #(
  parameter int unsigned CW    = pwm_trio_pkg::CNT_W_DEF,
  parameter int unsigned N_PWM = pwm_trio_pkg::N_PWM_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cnt_en,
  input  logic [N_PWM:0]          start_i,
  input  logic [N_PWM:0]          stop_i,
  input  logic [N_PWM:0]          wr_en,
  input  logic [CW-1:0]           wr_data,
  input  logic [N_PWM-1:0]        oe_i,
  input  logic [N_PWM-1:0]        lvl_i,
  output logic [(N_PWM+1)*CW-1:0] cnt_o,
  output logic [N_PWM:0]          run_o,
  output logic                    tick_o,
  output logic [N_PWM-1:0]        pwm_o
);
  logic rst_meta, rst_sync_n;
  logic tick;
  logic [N_PWM-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pwm_period_ch #(.CW(CW)) u_period (
    .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en),
    .start(start_i[0]), .stop(stop_i[0]), .wr(wr_en[0]), .wr_data(wr_data),
    .cnt(cnt_o[CW-1:0]), .run(run_o[0]), .tick(tick)
  );

  for (genvar k = 1; k <= N_PWM; k++) begin : g_duty
    pwm_duty_ch #(.CW(CW)) u_duty (
      .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .trig(tick),
      .start(start_i[k]), .stop(stop_i[k]), .wr(wr_en[k]), .wr_data(wr_data),
      .cnt(cnt_o[k*CW +: CW]), .run(run_o[k]), .level(level[k-1])
    );
    assign pwm_o[k-1] = oe_i[k-1] ? level[k-1] : lvl_i[k-1];
  end

  assign tick_o = tick;

  assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oe_i == '0) |-> (pwm_o == lvl_i));
endmodule

// File: tb/sim_pwm_trio_timer.sv
`timescale 1ns/1ps
module sim_pwm_trio_timer;
  localparam int CW = 16;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_en;
  logic [NP:0] start_i, stop_i, wr_en;
  logic [CW-1:0] wr_data;
  logic [NP-1:0] oe_i, lvl_i;
  logic [(NP+1)*CW-1:0] cnt_o;
  logic [NP:0] run_o;
  logic tick_o;
  logic [NP-1:0] pwm_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  logic [CW-1:0] m_cnt [0:NP];
  logic [CW-1:0] m_dat [0:NP];
  logic          m_run [0:NP];
  logic          m_act [1:NP];
  logic          m_pend[1:NP];
  logic          m_out [1:NP];

  always #2.5 clk = ~clk;

  pwm_trio_timer #(.CW(CW), .N_PWM(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_i(start_i), .stop_i(stop_i),
    .wr_en(wr_en), .wr_data(wr_data), .oe_i(oe_i), .lvl_i(lvl_i),
    .cnt_o(cnt_o), .run_o(run_o), .tick_o(tick_o), .pwm_o(pwm_o)
  );

  function automatic logic exp_tick();
    return m_run[0] && cnt_en && m_cnt[0] == '0 && !start_i[0] && !stop_i[0];
  endfunction

  function automatic logic exp_pin(int k);
    return oe_i[k-1] ? m_out[k] : lvl_i[k-1];
  endfunction

  task automatic model_reset();
    for (int k = 0; k <= NP; k++) begin
      m_cnt[k] = '0; m_dat[k] = '0; m_run[k] = 1'b0;
      if (k > 0) begin m_act[k] = 1'b0; m_pend[k] = 1'b0; m_out[k] = 1'b0; end
    end
  endtask

  task automatic model_step();
    logic t;
    t = exp_tick();
    for (int k = 1; k <= NP; k++) begin
      if (start_i[k]) begin m_run[k] = 1; m_act[k] = 0; m_pend[k] = 0; end
      else if (stop_i[k]) begin m_run[k] = 0; m_act[k] = 0; m_pend[k] = 0; end
      else if (m_run[k]) begin
        if (t) begin m_cnt[k] = m_dat[k]; m_act[k] = 1; m_pend[k] = 1; end
        else if (cnt_en && m_act[k]) begin
          if (m_cnt[k] == '0) begin m_out[k] = 0; m_act[k] = 0; end
          else begin m_cnt[k] = m_cnt[k] - 1'b1; if (m_pend[k]) m_out[k] = 1; end
          m_pend[k] = 0;
        end
      end
    end
    if (start_i[0]) begin m_run[0] = 1; m_cnt[0] = m_dat[0]; end
    else if (stop_i[0]) m_run[0] = 0;
    else if (m_run[0] && cnt_en) m_cnt[0] = t ? m_dat[0] : m_cnt[0] - 1'b1;
    for (int k = 0; k <= NP; k++) if (wr_en[k]) m_dat[k] = wr_data;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    string tg;
    chk(tick_o == exp_tick(), (tag == "") ? "R3" : tag, "tick_o", tick_o, exp_tick());
    for (int k = 0; k <= NP; k++) begin
      tg = (tag != "") ? tag : ((k == 0) ? "R3" : "R4");
      chk(cnt_o[k*CW +: CW] == m_cnt[k], tg, $sformatf("cnt%0d", k), cnt_o[k*CW +: CW], m_cnt[k]);
      chk(run_o[k] == m_run[k], (tag == "") ? "R2" : tag, $sformatf("run%0d", k), run_o[k], m_run[k]);
    end
    for (int k = 1; k <= NP; k++)
      chk(pwm_o[k-1] == exp_pin(k), (tag == "") ? "R5" : tag, $sformatf("pwm%0d", k), pwm_o[k-1], exp_pin(k));
  endtask

  task automatic cyc(input string tag);
    #1;
    compare(tag);
    model_step();
    @(negedge clk);
    start_i = '0; stop_i = '0; wr_en = '0;
  endtask

  task automatic wr(input int ch, input logic [CW-1:0] v, input string tag);
    wr_en[ch] = 1'b1; wr_data = v;
    cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int ones;
    void'($urandom(32'd1357));
    rst_n = 1'b0; cnt_en = 0; start_i = '0; stop_i = '0; wr_en = '0;
    wr_data = '0; oe_i = '1; lvl_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    #1;
    chk(cnt_o == '0, "R1", "cnt_o", cnt_o, 0);
    chk(run_o == '0, "R1", "run_o", run_o, 0);
    chk(tick_o == 1'b0, "R1", "tick_o", tick_o, 0);
    chk(pwm_o == '0, "R1", "pwm_o", pwm_o, 0);
    @(negedge clk);

    // period 6, duty 2 on channel 1, duty 0 on channel 2
    wr(0, 16'd5, "R1"); wr(1, 16'd2, "R1"); wr(2, 16'd0, "R1");
    start_i = 3'b111; cnt_en = 1; cyc("R2");
    for (int i = 0; i < 24; i++) begin
      chk(pwm_o[1] == 1'b0, "R6", "pwm2 zero duty", pwm_o[1], 0);
      cyc("");
    end
    // rewrite channel 2 above the period mid-run: R9, 100 percent R6
    wr_en[2] = 1; wr_data = 16'd9; cyc("R9");
    wr_en[0] = 1; wr_data = 16'd3; cyc("R9");
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      if (i >= 12) chk(pwm_o[1] == 1'b1, "R6", "pwm2 full duty", pwm_o[1], 1);
      cyc("");
    end
    // stop all: counters and pins hold
    stop_i = 3'b111; cyc("R7");
    for (int i = 0; i < 12; i++) begin
      cnt_en = $urandom_range(0, 1);
      cyc("R7");
    end
    // pins follow software level when disabled
    for (int i = 0; i < 8; i++) begin
      oe_i = 2'b00; lvl_i = 2'($urandom_range(0, 3));
      #1; chk(pwm_o == lvl_i, "R8", "pin level", pwm_o, lvl_i);
      cyc("R8");
    end
    oe_i = 2'b11;
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cnt_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) begin
        wr_en[$urandom_range(0, 2)] = 1'b1;
        wr_data = 16'($urandom_range(0, 12));
      end
      if ($urandom_range(0, 150) == 0) start_i = 3'($urandom_range(1, 7));
      else if ($urandom_range(0, 400) == 0) stop_i = 3'($urandom_range(1, 7));
      if (i % 500 == 0) start_i = 3'b111;
      if ($urandom_range(0, 60) == 0) oe_i = 2'($urandom_range(0, 3));
      lvl_i = 2'($urandom_range(0, 3));
      cyc((i % 2 == 0) ? "" : "R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule